// File: doc/BRIEF.md
# Control and status register unit

This unit holds the architectural control state of a processor core: a program counter, an instruction-set-mode bit, a 32-bit status register and a bank of 64 control registers, each 64 bits wide. The execute stage writes the program counter through a dedicated port. Bit 0 of each value written there selects the instruction-set mode: it is moved into the mode bit, and the program counter keeps the value with bit 0 cleared. No port can write the mode bit directly. A direct write attempt is refused and reported on an error output.

The control-register bank has one combinational read port and one write port. Both are indexed by a 6-bit number. Index 0 is not a storage slot. It is a window onto the status register: a read returns the status register zero-extended to 64 bits, and a write loads the status register from the low 32 bits. Six named status flags also have their own single-bit ports. A flag write replaces one status bit and leaves every other bit as it was. Decoding instructions and giving meaning to the flags are left to the rest of the core.

Top module: `csr_unit`

## Requirements
- R1: When `pc_we_i` is high at a rising edge, from that edge `pc_o` equals `pc_wdata_i` with bit 0 forced to 0, and `mode_o` equals `pc_wdata_i[0]`.
- R2: The pulse `mode_we_i` is a direct write attempt on the mode bit, and it has no effect on `mode_o`. In the cycle after a rising edge, `mode_err_o` is 1 if `mode_we_i` was high at that edge and 0 if it was low.
- R3: A write with `cr_we_i` high and `cr_waddr_i` from 1 to 63 stores all 64 bits of `cr_wdata_i`. A read at that index returns the stored value, and the other indices keep their contents.
- R4: A read at index 0 returns `{32'h0, sr_o}`. A write at index 0 loads `sr_o` from `cr_wdata_i[31:0]`, and bits 63:32 of the written value are discarded.
- R5: The flag ports map to status bits as follows: index 0 is bit 14 (register-bank select), index 1 is bit 13 (transfer size), index 2 is bit 12 (precision), index 3 is bit 9 (divide M), index 4 is bit 8 (divide Q) and index 5 is bit 1 (saturation). `flag_o[k]` shows the status bit mapped to index k.
- R6: When `flag_we_i[k]` is high at an edge, only the status bit mapped to k takes `flag_wdata_i[k]`, and all other status bits keep their values. Several flags may be written in the same cycle.
- R7: When a write at control-register index 0 and any flag write occur at the same edge, `sr_o` takes the low 32 bits of the full write.
- R8: While `rst_ni` is low, the PC, the mode bit, the error output, the status register and all control registers read as zero.
- R9: Reads are combinational. During a cycle that writes an index, a read at that index returns the old contents, and the new value appears after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_we_i | input | 1 | Program counter write enable |
| pc_wdata_i | input | 64 | New program counter value; bit 0 selects the mode |
| pc_o | output | 64 | Program counter; bit 0 is always 0 |
| mode_o | output | 1 | Instruction-set-mode bit |
| mode_we_i | input | 1 | Direct write attempt on the mode bit (refused) |
| mode_err_o | output | 1 | High for one cycle after a refused attempt |
| cr_we_i | input | 1 | Control-register write enable |
| cr_waddr_i | input | 6 | Control-register write index |
| cr_wdata_i | input | 64 | Control-register write data |
| cr_raddr_i | input | 6 | Control-register read index |
| cr_rdata_o | output | 64 | Control-register read data (combinational) |
| flag_we_i | input | 6 | Per-flag write enables |
| flag_wdata_i | input | 6 | Per-flag write values |
| flag_o | output | 6 | Current flag values |
| sr_o | output | 32 | Status register |

## Verification
The bench checks PC values with odd and with even low bits. A design that copies bit 0 into the PC, or that fails to update the mode bit, shows a wrong `pc_o` or a wrong `mode_o`. It makes direct mode-write attempts both alone and in the same cycle as a PC write. There a leaky design would change `mode_o` or would fail to raise `mode_err_o` for exactly one cycle. It drives flag writes over an all-ones and an all-zeros status register, including a clash with a full write at index 0. A design that drops neighbouring bits, that uses the wrong bit positions or that lets a flag win the clash shows a wrong `sr_o`. Read-during-write cycles and upper-half data sent to index 0 catch a bank that forwards the new value too early or that keeps status bits above bit 31.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN    = 64;
  localparam int SR_W    = 32;
  localparam int N_CR    = 64;
  localparam int N_FLAG  = 6;

  // status bit carried by each named flag port
  function automatic int flag_bit(input int k);
    case (k)
      0:       flag_bit = 14;
      1:       flag_bit = 13;
      2:       flag_bit = 12;
      3:       flag_bit = 9;
      4:       flag_bit = 8;
      default: flag_bit = 1;
    endcase
  endfunction
endpackage

// File: rtl/csr_pc_mode.sv
module csr_pc_mode #(
  parameter int XLEN = csr_pkg::XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pc_we_i,
  input  logic [XLEN-1:0] pc_wdata_i,
  input  logic            mode_we_i,
  output logic [XLEN-1:0] pc_o,
  output logic            mode_o,
  output logic            mode_err_o
);
  logic [XLEN-1:1] pc_q;
  logic            mode_q;
  logic            err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mode_q <= 1'b0;
    end else if (pc_we_i) begin
      pc_q   <= pc_wdata_i[XLEN-1:1];
      mode_q <= pc_wdata_i[0];
    end
  end

  // direct mode writes are refused, only reported
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= mode_we_i;
  end

  assign pc_o       = {pc_q, 1'b0};
  assign mode_o     = mode_q;
  assign mode_err_o = err_q;
endmodule

// File: rtl/csr_status.sv
module csr_status #(
  parameter int SR_W   = csr_pkg::SR_W,
  parameter int N_FLAG = csr_pkg::N_FLAG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] flag_we_i,
  input  logic [N_FLAG-1:0] flag_wdata_i,
  input  logic              full_we_i,
  input  logic [SR_W-1:0]   full_wdata_i,
  output logic [SR_W-1:0]   sr_o,
  output logic [N_FLAG-1:0] flag_o
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    for (int k = 0; k < N_FLAG; k++) begin
      if (flag_we_i[k]) sr_d[csr_pkg::flag_bit(k)] = flag_wdata_i[k];
    end
    if (full_we_i) sr_d = full_wdata_i;  // full write has priority
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    assign flag_o[g] = sr_q[csr_pkg::flag_bit(g)];
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int XLEN = csr_pkg::XLEN,
  parameter int N_CR = csr_pkg::N_CR,
  localparam int AW  = $clog2(N_CR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem [N_CR];

  // slot 0 is the status alias and holds no storage
  assign mem[0] = '0;

  for (genvar g = 1; g < N_CR; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g)) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/csr_unit.sv
module csr_unit #(
  parameter int XLEN   = csr_pkg::XLEN,
  parameter int SR_W   = csr_pkg::SR_W,
  parameter int N_CR   = csr_pkg::N_CR,
  parameter int N_FLAG = csr_pkg::N_FLAG,
  localparam int AW    = $clog2(N_CR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_we_i,
  input  logic [XLEN-1:0]   pc_wdata_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              mode_o,
  input  logic              mode_we_i,
  output logic              mode_err_o,
  input  logic              cr_we_i,
  input  logic [AW-1:0]     cr_waddr_i,
  input  logic [XLEN-1:0]   cr_wdata_i,
  input  logic [AW-1:0]     cr_raddr_i,
  output logic [XLEN-1:0]   cr_rdata_o,
  input  logic [N_FLAG-1:0] flag_we_i,
  input  logic [N_FLAG-1:0] flag_wdata_i,
  output logic [N_FLAG-1:0] flag_o,
  output logic [SR_W-1:0]   sr_o
);
  logic            sr_full_we;
  logic            bank_we;
  logic [XLEN-1:0] bank_rdata;
  logic [SR_W-1:0] sr_q;
  logic            wr_alias;

  assign wr_alias   = (cr_waddr_i == '0);
  assign sr_full_we = cr_we_i && wr_alias;
  assign bank_we    = cr_we_i && !wr_alias;

  csr_pc_mode #(.XLEN(XLEN)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_we_i    (pc_we_i),
    .pc_wdata_i (pc_wdata_i),
    .mode_we_i  (mode_we_i),
    .pc_o       (pc_o),
    .mode_o     (mode_o),
    .mode_err_o (mode_err_o)
  );

  csr_status #(.SR_W(SR_W), .N_FLAG(N_FLAG)) u_sr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .full_we_i    (sr_full_we),
    .full_wdata_i (cr_wdata_i[SR_W-1:0]),
    .sr_o         (sr_q),
    .flag_o       (flag_o)
  );

  csr_bank #(.XLEN(XLEN), .N_CR(N_CR)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .waddr_i (cr_waddr_i),
    .wdata_i (cr_wdata_i),
    .raddr_i (cr_raddr_i),
    .rdata_o (bank_rdata)
  );

  assign cr_rdata_o = (cr_raddr_i == '0) ? {{(XLEN-SR_W){1'b0}}, sr_q} : bank_rdata;
  assign sr_o       = sr_q;
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter int XLEN   = csr_pkg::XLEN,
  parameter int SR_W   = csr_pkg::SR_W,
  parameter int N_CR   = csr_pkg::N_CR,
  parameter int N_FLAG = csr_pkg::N_FLAG,
  localparam int AW    = $clog2(N_CR)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pc_we_i,
  input logic [XLEN-1:0]   pc_wdata_i,
  input logic [XLEN-1:0]   pc_o,
  input logic              mode_o,
  input logic              mode_we_i,
  input logic              mode_err_o,
  input logic              cr_we_i,
  input logic [AW-1:0]     cr_waddr_i,
  input logic [XLEN-1:0]   cr_wdata_i,
  input logic [AW-1:0]     cr_raddr_i,
  input logic [XLEN-1:0]   cr_rdata_o,
  input logic [N_FLAG-1:0] flag_we_i,
  input logic [N_FLAG-1:0] flag_wdata_i,
  input logic [N_FLAG-1:0] flag_o,
  input logic [SR_W-1:0]   sr_o
);
  // R1
  pc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> (pc_o == {$past(pc_wdata_i[XLEN-1:1]), 1'b0}) && (mode_o == $past(pc_wdata_i[0])));

  // R2
  mode_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !pc_we_i) |=> $stable(mode_o));

  // R2
  mode_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mode_err_o == $past(mode_we_i)));

  // R3
  bank_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && cr_waddr_i != '0 && !(flag_we_i != '0 && 1'b0)) ##1 (cr_raddr_i == $past(cr_waddr_i))
      |-> cr_rdata_o == $past(cr_wdata_i));

  // R4
  alias_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_raddr_i == '0) |-> (cr_rdata_o == {{(XLEN-SR_W){1'b0}}, sr_o}));

  // R7
  full_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && cr_waddr_i == '0) |=> (sr_o == $past(cr_wdata_i[SR_W-1:0])));

  // R6
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i == '0 && !(cr_we_i && cr_waddr_i == '0)) |=> $stable(sr_o));

  for (genvar g = 0; g < N_FLAG; g++) begin : g_fchk
    // R5
    flag_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[g] == sr_o[csr_pkg::flag_bit(g)]);
    // R6
    flag_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_we_i[g] && !(cr_we_i && cr_waddr_i == '0)) |=> (flag_o[g] == $past(flag_wdata_i[g])));
  end
endmodule

bind csr_unit csr_unit_chk #(
  .XLEN(XLEN), .SR_W(SR_W), .N_CR(N_CR), .N_FLAG(N_FLAG)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_we_i      (pc_we_i),
  .pc_wdata_i   (pc_wdata_i),
  .pc_o         (pc_o),
  .mode_o       (mode_o),
  .mode_we_i    (mode_we_i),
  .mode_err_o   (mode_err_o),
  .cr_we_i      (cr_we_i),
  .cr_waddr_i   (cr_waddr_i),
  .cr_wdata_i   (cr_wdata_i),
  .cr_raddr_i   (cr_raddr_i),
  .cr_rdata_o   (cr_rdata_o),
  .flag_we_i    (flag_we_i),
  .flag_wdata_i (flag_wdata_i),
  .flag_o       (flag_o),
  .sr_o         (sr_o)
);

// File: tb/csr_unit_tb_top.sv
module csr_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pc_we_i = 1'b0;
  logic [63:0] pc_wdata_i = '0;
  logic [63:0] pc_o;
  logic        mode_o;
  logic        mode_we_i = 1'b0;
  logic        mode_err_o;
  logic        cr_we_i = 1'b0;
  logic [5:0]  cr_waddr_i = '0;
  logic [63:0] cr_wdata_i = '0;
  logic [5:0]  cr_raddr_i = '0;
  logic [63:0] cr_rdata_o;
  logic [5:0]  flag_we_i = '0;
  logic [5:0]  flag_wdata_i = '0;
  logic [5:0]  flag_o;
  logic [31:0] sr_o;

  always #5 clk_i = ~clk_i;

  csr_unit dut_i (.*);

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  logic [63:0] m_pc = '0;
  logic        m_mode = 1'b0;
  logic        m_err = 1'b0;
  logic [31:0] m_sr = '0;
  logic [63:0] m_bank [64];

  function automatic int pos_of(input int k);
    int p [6] = '{14, 13, 12, 9, 8, 1};
    return p[k];
  endfunction

  function automatic logic [63:0] m_read(input logic [5:0] a);
    return (a == 6'd0) ? {32'h0, m_sr} : m_bank[a];
  endfunction

  function automatic logic [5:0] m_flags();
    logic [5:0] f;
    for (int k = 0; k < 6; k++) f[k] = m_sr[pos_of(k)];
    return f;
  endfunction

  function automatic logic [63:0] actual(input int sel);
    case (sel)
      0: return pc_o;
      1: return {63'h0, mode_o};
      2: return {63'h0, mode_err_o};
      3: return {32'h0, sr_o};
      4: return cr_rdata_o;
      default: return {58'h0, flag_o};
    endcase
  endfunction

  task automatic compare(input int sel, input logic [63:0] exp, input string tag);
    logic [63:0] act;
    act = actual(sel);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, act, exp);
    end
  endtask

  task automatic push(input int sel, input logic [63:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare results registered at each edge
  always @(posedge clk_i) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      compare(it.sel, it.exp, it.tag);
    end
  end

  task automatic drive(input string tag,
                       input logic pwe, input logic [63:0] pd, input logic mwe,
                       input logic cwe, input logic [5:0] wa, input logic [63:0] wd,
                       input logic [5:0] ra, input logic [5:0] fwe, input logic [5:0] fwd);
    @(negedge clk_i);
    pc_we_i = pwe; pc_wdata_i = pd; mode_we_i = mwe;
    cr_we_i = cwe; cr_waddr_i = wa; cr_wdata_i = wd; cr_raddr_i = ra;
    flag_we_i = fwe; flag_wdata_i = fwd;
    #1;
    // R9: combinational read shows old contents before the edge
    if (cwe && wa == ra) compare(4, m_read(ra), {tag, " R9 pre-edge"});
    m_err = mwe;
    if (pwe) begin
      m_pc = {pd[63:1], 1'b0};
      m_mode = pd[0];
    end
    for (int k = 0; k < 6; k++) if (fwe[k]) m_sr[pos_of(k)] = fwd[k];
    if (cwe && wa == 6'd0) m_sr = wd[31:0];
    else if (cwe) m_bank[wa] = wd;
    push(0, m_pc, tag);
    push(1, {63'h0, m_mode}, tag);
    push(2, {63'h0, m_err}, tag);
    push(3, {32'h0, m_sr}, tag);
    push(4, m_read(ra), tag);
    push(5, {58'h0, m_flags()}, tag);
  endtask

  task automatic idle(input string tag, input logic [5:0] ra);
    drive(tag, 0, '0, 0, 0, '0, '0, ra, '0, '0);
  endtask

  task automatic flag_wr(input string tag, input logic [5:0] fwe, input logic [5:0] fwd);
    drive(tag, 0, '0, 0, 0, '0, '0, 6'd0, fwe, fwd);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_bank[i] = '0;
    // R8: reset state
    repeat (2) @(negedge clk_i);
    compare(0, 64'h0, "R8 pc");
    compare(1, 64'h0, "R8 mode");
    compare(2, 64'h0, "R8 err");
    compare(3, 64'h0, "R8 sr");
    cr_raddr_i = 6'd0; #1 compare(4, 64'h0, "R8 cr0");
    cr_raddr_i = 6'd63; #1 compare(4, 64'h0, "R8 cr63");
    cr_raddr_i = 6'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: odd and even PC values
    drive("R1 odd", 1, 64'h1234_5678_9abc_def1, 0, 0, '0, '0, '0, '0, '0);
    drive("R1 even", 1, 64'hfedc_ba98_7654_3210, 0, 0, '0, '0, '0, '0, '0);
    drive("R1 max", 1, 64'hffff_ffff_ffff_ffff, 0, 0, '0, '0, '0, '0, '0);
    // R2: direct mode attempt alone, then with a PC write
    drive("R2 poke", 0, '0, 1, 0, '0, '0, '0, '0, '0);
    idle("R2 err clears", 6'd0);
    drive("R2 poke+pc", 1, 64'h0000_0000_0000_0100, 1, 0, '0, '0, '0, '0, '0);
    idle("R2 idle", 6'd0);

    // R3: bank writes at the edges and middle
    drive("R3 w1", 0, '0, 0, 1, 6'd1, 64'hdead_beef_0123_4567, 6'd1, '0, '0);
    drive("R3 w63", 0, '0, 0, 1, 6'd63, 64'h8000_0000_0000_0001, 6'd63, '0, '0);
    drive("R3 w37", 0, '0, 0, 1, 6'd37, 64'h5555_aaaa_5555_aaaa, 6'd1, '0, '0);
    idle("R3 rd37", 6'd37);
    idle("R3 rd63", 6'd63);
    idle("R3 rd2", 6'd2);

    // R4: alias with upper-half data discarded
    drive("R4 w0", 0, '0, 0, 1, 6'd0, 64'hffff_ffff_a5a5_5a5a, 6'd0, '0, '0);
    idle("R4 rd0", 6'd0);

    // R5/R6: single flags from zero, then clear from all-ones
    drive("R6 zero", 0, '0, 0, 1, 6'd0, 64'h0, 6'd0, '0, '0);
    for (int k = 0; k < 6; k++) begin
      flag_wr("R5 set one", 6'(1 << k), 6'h3f);
      flag_wr("R6 clear one", 6'(1 << k), 6'h00);
    end
    drive("R6 ones", 0, '0, 0, 1, 6'd0, 64'hffff_ffff, 6'd0, '0, '0);
    flag_wr("R6 clr bank", 6'b000001, 6'b000000);
    flag_wr("R6 clr sat", 6'b100000, 6'b000000);
    flag_wr("R6 multi", 6'b011110, 6'b010100);
    // R7: clash between a full write and flag writes
    drive("R7 clash", 0, '0, 0, 1, 6'd0, 64'h0000_0000_0000_4302, 6'd0, 6'h3f, 6'h00);
    drive("R7 clash2", 0, '0, 0, 1, 6'd0, 64'h0, 6'd0, 6'h3f, 6'h3f);

    // R9: read during write on bank and on alias
    drive("R9 bank", 0, '0, 0, 1, 6'd9, 64'h0f0f_0f0f_0f0f_0f0f, 6'd9, '0, '0);
    drive("R9 bank2", 0, '0, 0, 1, 6'd9, 64'h1111_2222_3333_4444, 6'd9, '0, '0);
    drive("R9 alias", 0, '0, 0, 1, 6'd0, 64'h0000_0000_1357_9bdf, 6'd0, '0, '0);
    idle("R3 rd1 kept", 6'd1);
    idle("final", 6'd9);

    @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule